// File: doc/BRIEF.md
# Microsecond Interval Timer with Optional Millisecond Prescaler

This block is a periodic interval timer for an 8-bit peripheral bus. It counts a shared one-microsecond tick pulse that arrives from outside. Each time a programmed interval runs out, it raises a single-cycle interrupt request. It then reloads itself and starts the next interval with no software action. Software writes the interval register through a simple write strobe and can read the register back at any time.

Two build-time parameters select variants of the block. `MS_MODE` places a divide-by-`PRE_DIV` prescaler (1000 by default) between the microsecond tick and the down counter. The timer unit then becomes one millisecond, so the 8-bit register spans 1 to 256 ms. Software cannot see or change this choice. `WR_GUARD` makes the block accept register writes only while the CPU interrupt flag input is high. This keeps ordinary task code from reprogramming a scheduler tick.

Top module: `interval_tick_timer`

## Requirements
- R1: After reset, `irq` is low and `rd_data` reads `RESET_VAL` (all ones by default). Counting starts as if that value had just been written.
- R2: A register value N gives a period of N+1 timer units. A value of 0 expires on every unit and a value of 255 expires every 256 units.
- R3: Each expiry asserts `irq` for one clock cycle, in the cycle after the clock edge that sampled the expiring unit. `irq` is never high in a cycle that does not follow an `us_tick` sample.
- R4: On expiry the counter reloads from the interval register. Later periods have the same length, and the register value does not change.
- R5: An accepted write puts `wr_data` on `rd_data` from the next cycle. It also restarts the count, so the next expiry comes N+1 units after the write edge.
- R6: With `WR_GUARD`=1, a write while `priv_flag` is low has no effect: `rd_data` and the interrupt timing do not change. The same write with `priv_flag` high is accepted.
- R7: With `MS_MODE`=1, one timer unit equals `PRE_DIV` microsecond ticks. An accepted write also clears the prescaler, so the first expiry comes exactly (N+1)·`PRE_DIV` ticks after the write.
- R8: With `WR_GUARD`=0, writes are accepted whatever the value of `priv_flag`.
- R9: If an accepted write and an expiring unit fall in the same cycle, the write wins. No interrupt is raised and the new count starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| wr_en | input | 1 | Write strobe for the interval register |
| wr_data | input | CNT_W | New interval value N |
| priv_flag | input | 1 | CPU interrupt flag; qualifies writes when `WR_GUARD`=1 |
| rd_data | output | CNT_W | Current interval register value |
| irq | output | 1 | Single-cycle interrupt request on expiry |

## Verification
The assertions assume `us_tick` is a clean synchronous pulse. It may be high on consecutive cycles, and the checks tie `irq` to a tick seen one cycle earlier. They also assume `wr_en` and `wr_data` are stable around the sampling edge. The stimulus drives every input on the falling clock edge. In the random phase it mixes ticks at about half density with sparse writes, random flag values, and interval values biased toward 0 to 5 so that many expiries occur. Directed cases cover a write landing on an expiry, and a prescaled count interrupted part way through.

// File: rtl/interval_tick_timer.sv
module interval_tick_timer #(
  parameter int              CNT_W     = 8,
  parameter bit              MS_MODE   = 1'b0,
  parameter bit              WR_GUARD  = 1'b1,
  parameter int              PRE_DIV   = 1000,
  parameter logic [CNT_W-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             us_tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             priv_flag,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);

  logic             wr_ok;
  logic             unit_en;
  logic [CNT_W-1:0] ival;
  logic [CNT_W-1:0] cnt;

  assign wr_ok   = wr_en && (priv_flag || !WR_GUARD);
  assign rd_data = ival;

  generate
    if (MS_MODE) begin : g_ms
      localparam int PW = $clog2(PRE_DIV);
      logic [PW-1:0] pre;
      logic          pre_last;
      assign pre_last = (pre == PW'(PRE_DIV - 1));
      assign unit_en  = us_tick && pre_last;
      always_ff @(posedge clk) begin
        if (rst || wr_ok)
          pre <= '0;
        else if (us_tick)
          pre <= pre_last ? '0 : pre + PW'(1);
      end
    end else begin : g_us
      assign unit_en = us_tick;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ival <= RESET_VAL;
      cnt  <= RESET_VAL;
      irq  <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (wr_ok) begin
        ival <= wr_data;
        cnt  <= wr_data;
      end else if (unit_en) begin
        if (cnt == '0) begin
          cnt <= ival;
          irq <= 1'b1;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/interval_tick_timer_chk.sv
module interval_tick_timer_chk #(
  parameter int CNT_W    = 8,
  parameter bit WR_GUARD = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             us_tick,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic             priv_flag,
  input logic [CNT_W-1:0] rd_data,
  input logic             irq
);

  logic accepted;
  assign accepted = wr_en && (priv_flag || !WR_GUARD);

  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    !us_tick |=> !irq);  // R3
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    accepted |=> rd_data == $past(wr_data));  // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    accepted |=> !irq);  // R9
  AST_GUARD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (WR_GUARD && wr_en && !priv_flag) |=> $stable(rd_data));  // R6
  AST_RELOAD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data));  // R4

endmodule

bind interval_tick_timer interval_tick_timer_chk #(.CNT_W(CNT_W), .WR_GUARD(WR_GUARD)) u_chk (
  .clk(clk), .rst(rst), .us_tick(us_tick), .wr_en(wr_en), .wr_data(wr_data),
  .priv_flag(priv_flag), .rd_data(rd_data), .irq(irq)
);

// File: tb/interval_tick_timer_test.sv
`timescale 1ns/1ps
module interval_tick_timer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, we = 1'b0, flag = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rd;
  logic irq;
  logic mtick = 1'b0, mwe = 1'b0, mflag = 1'b0;
  logic [7:0] mwd = '0;
  logic [7:0] mrd;
  logic mirq;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  interval_tick_timer #(.MS_MODE(1'b0), .WR_GUARD(1'b1)) uut (
    .clk(clk), .rst(rst), .us_tick(tick), .wr_en(we), .wr_data(wd),
    .priv_flag(flag), .rd_data(rd), .irq(irq));

  interval_tick_timer #(.MS_MODE(1'b1), .WR_GUARD(1'b0), .PRE_DIV(1000)) uut_ms (
    .clk(clk), .rst(rst), .us_tick(mtick), .wr_en(mwe), .wr_data(mwd),
    .priv_flag(mflag), .rd_data(mrd), .irq(mirq));

  // reference: units seen since last restart; expiry when that equals N
  int   m_int = 255, m_seen = 0;
  logic m_irq = 1'b0;

  function automatic bit accepted(input logic w, input logic f);
    return w && f;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_int <= 255; m_seen <= 0; m_irq <= 1'b0;
    end else if (accepted(we, flag)) begin
      m_int <= int'(wd); m_seen <= 0; m_irq <= 1'b0;
    end else if (tick) begin
      if (m_seen == m_int) begin m_irq <= 1'b1; m_seen <= 0; end
      else begin m_irq <= 1'b0; m_seen <= m_seen + 1; end
    end else m_irq <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !finished) begin
    chk(irq == m_irq, "R2 model irq", irq, m_irq);
    chk(int'(rd) == m_int, "R4 model rd_data", rd, m_int);
  end

  task automatic step(input logic t, input logic w, input logic [7:0] d, input logic f);
    tick = t; we = w; wd = d; flag = f;
    @(posedge clk); @(negedge clk);
    tick = 1'b0; we = 1'b0;
  endtask

  task automatic mstep(input logic t, input logic w, input logic [7:0] d);
    mtick = t; mwe = w; mwd = d; mflag = 1'b0;
    @(posedge clk); @(negedge clk);
    mtick = 1'b0; mwe = 1'b0;
  endtask

  task automatic run_period(input int n, input string req);
    int early = 0;
    for (int k = 0; k < n; k++) begin
      step(1'b1, 1'b0, 8'd0, 1'b0);
      if (irq) early++;
    end
    chk(early == 0, req, early, 0);
    step(1'b1, 1'b0, 8'd0, 1'b0);
    chk(irq == 1'b1, req, irq, 1);
  endtask

  task automatic ms_count(input int limit, output int hit);
    hit = -1;
    for (int k = 1; k <= limit; k++) begin
      mstep(1'b1, 1'b0, 8'd0);
      if (mirq && hit < 0) hit = k;
    end
  endtask

  initial begin
    int hit;
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    chk(rd == 8'hFF, "R1 rd_data after reset", rd, 255);
    chk(mrd == 8'hFF, "R1 ms rd_data after reset", mrd, 255);

    step(1'b0, 1'b1, 8'd3, 1'b1);
    chk(rd == 8'd3, "R5 write loads", rd, 3);
    run_period(3, "R2 period N=3");
    step(1'b0, 1'b0, 8'd0, 1'b0);
    chk(irq == 1'b0, "R3 single cycle pulse", irq, 0);
    run_period(3, "R4 reload same period");
    chk(rd == 8'd3, "R4 register kept", rd, 3);

    step(1'b0, 1'b1, 8'd0, 1'b1);
    step(1'b1, 1'b0, 8'd0, 1'b0);
    chk(irq == 1'b1, "R2 N=0 first unit", irq, 1);
    step(1'b1, 1'b0, 8'd0, 1'b0);
    chk(irq == 1'b1, "R2 N=0 every unit", irq, 1);

    step(1'b0, 1'b1, 8'd9, 1'b0);
    chk(rd == 8'd0, "R6 guarded write ignored", rd, 0);
    step(1'b1, 1'b0, 8'd0, 1'b0);
    chk(irq == 1'b1, "R6 timing unchanged", irq, 1);
    step(1'b0, 1'b1, 8'd9, 1'b1);
    chk(rd == 8'd9, "R6 flagged write accepted", rd, 9);

    step(1'b0, 1'b1, 8'd2, 1'b1);
    step(1'b1, 1'b0, 8'd0, 1'b0);
    step(1'b1, 1'b0, 8'd0, 1'b0);
    step(1'b1, 1'b1, 8'd5, 1'b1);
    chk(irq == 1'b0, "R9 write beats expiry", irq, 0);
    chk(rd == 8'd5, "R9 new value loaded", rd, 5);
    run_period(5, "R5 restart after write");

    step(1'b0, 1'b1, 8'd255, 1'b1);
    run_period(255, "R2 period N=255");

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] d;
      d = ($urandom % 4 == 0) ? 8'($urandom % 256) : 8'($urandom % 6);
      step(1'($urandom % 2), ($urandom % 20 == 0), d, 1'($urandom % 2));
    end

    mstep(1'b0, 1'b1, 8'd1);
    chk(mrd == 8'd1, "R8 write without flag accepted", mrd, 1);
    ms_count(2100, hit);
    chk(hit == 2000, "R7 ms period N=1", hit, 2000);
    ms_count(2000, hit);
    chk(hit == 1900, "R4 ms reload", hit, 1900);
    for (int k = 0; k < 500; k++) mstep(1'b1, 1'b0, 8'd0);
    mstep(1'b0, 1'b1, 8'd0);
    ms_count(1100, hit);
    chk(hit == 1000, "R7 write clears prescaler", hit, 1000);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule